// File: doc/BRIEF.md
# Vectored Prioritised Interrupt Controller

This block collects 32 external interrupt lines and three system exceptions (a non-maskable request, a hard-fault request and a periodic tick request). On every cycle it chooses the one exception that should be serviced next and presents its exception number and the address of its vector-table word. The controller sits next to a processor core. The core takes the chosen exception with a one-cycle entry strobe and later reports the end of the handler with a return strobe and the exception number.

Software programs the block over a simple 32-bit register bus with word addresses. Enable and pending state each have a separate set register and clear register, so a write of 1 changes only the bits it names. A bank of priority words holds one byte per line. The block tracks which exceptions are active and raises a preemption flag when the chosen exception outranks everything now being serviced. Each line is built as either edge-captured or level-captured, chosen per line by a parameter (default: lines 0 to 15 edge, lines 16 to 31 level).

Top module: `vpic_top`

## Requirements
- R1: External line n is exception number 16+n, and `irq_vector` equals 4 times `irq_num` (table base 0), so line 31 gives number 47 and vector 0xBC.
- R2: Writing the word at 0x100 sets every enable bit whose data bit is 1. Writing 0x180 clears every enable bit whose data bit is 1. Data bits of 0 leave the enable unchanged, and reading either address returns the 32 enable bits.
- R3: Writes to 0x200 and 0x280 set and clear the pending bits of lines in the same way, and reading either address returns the 32 line pending bits.
- R4: The priority word at 0x400+4k holds lines 4k to 4k+3, one per byte, with byte j (bits 8j+7:8j) for line 4k+j. Only the top two bits of each byte are stored, and the other bits read 0.
- R5: Among enabled pending lines, the lowest priority value wins, and equal values resolve to the lowest exception number. A pending line that is not enabled is never chosen.
- R6: The non-maskable request (exception 2, `sys_req[0]`) beats the hard fault (exception 3, `sys_req[1]`), and both beat every configurable priority. A request input sets its pending bit on each cycle it is high.
- R7: The tick exception (15, `sys_req[2]`) takes its 2-bit priority from bits 31:30 of the word at 0xD20. It competes with the lines under R5.
- R8: `irq_preempt` is high when an exception is chosen and its priority is strictly better than the best priority among active exceptions, or when nothing is active. An equal priority does not preempt.
- R9: `ent_take` clears the pending bit of the chosen exception and marks it active in the same edge. `ret_take` with `ret_num` clears that exception's active bit.
- R10: An edge-captured line sets pending on a 0-to-1 input transition, seen one cycle later. A held-high input does not pend again after it is taken.
- R11: A level-captured line is pending while its input is high and it is not active. After a return with the input still high, it is pending again one cycle after the return edge.
- R12: After reset, enables, pending bits, priorities and active bits are 0 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_in | input | 32 | External interrupt lines |
| sys_req | input | 3 | Requests: [0] non-maskable, [1] hard fault, [2] tick |
| ent_take | input | 1 | Core enters the chosen exception |
| ret_take | input | 1 | Core returns from an exception |
| ret_num | input | 6 | Exception number being returned from |
| irq_valid | output | 1 | An exception is chosen |
| irq_num | output | 6 | Chosen exception number |
| irq_vector | output | 32 | Vector-table word address of the chosen exception |
| irq_preempt | output | 1 | Chosen exception may preempt the active one |

## Verification
The checker watches on every cycle that a set-enable write never clears an enable bit and a clear-enable write never sets one. It also checks that any enabled pending line produces a valid choice, that a pending non-maskable request always wins, that preemption never appears without a choice, and that an entry marks the chosen exception active. Only the directed scenarios can show the exact ordering results: tie-breaking by number, the strict comparison against an equal active priority, masking of the low priority bits, and the cycle at which a level line pends again after return, compared with a pulse line that stays quiet.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NLINES    = 32;
  localparam int LINE_BASE = 16;
  localparam int NEXC      = LINE_BASE + NLINES;
  localparam int NUM_W     = $clog2(NEXC);
  localparam int PRIO_W    = 2;
  localparam int NSYS      = 3;
  // ranks: 0 = non-maskable, 1 = hard fault, 2.. = configurable, all ones = none
  localparam int RANK_W    = $clog2(2 + (1 << PRIO_W) + 1);
  localparam logic [RANK_W-1:0] RANK_NONE = '1;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;

  localparam int EXC_NMI   = 2;
  localparam int EXC_HF    = 3;
  localparam int EXC_TICK  = 15;

  localparam logic [ADDR_W-1:0] A_EN_SET   = 12'h100;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 12'h180;
  localparam logic [ADDR_W-1:0] A_PND_SET  = 12'h200;
  localparam logic [ADDR_W-1:0] A_PND_CLR  = 12'h280;
  localparam logic [ADDR_W-1:0] A_PRIO     = 12'h400;
  localparam logic [ADDR_W-1:0] A_TICKPRIO = 12'hD20;
endpackage

// File: rtl/vpic_regfile.sv
module vpic_regfile
  import vpic_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [NLINES-1:0]             line_pend,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NLINES-1:0]             line_en,
  output logic [NLINES-1:0][PRIO_W-1:0] line_prio,
  output logic [PRIO_W-1:0]             tick_prio,
  output logic [NLINES-1:0]             pend_set,
  output logic [NLINES-1:0]             pend_clr
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int LOW_ZERO       = 8 - PRIO_W;

  logic                          wr;
  logic [NLINES-1:0]             en_n;
  logic [NLINES-1:0][PRIO_W-1:0] prio_n;
  logic [PRIO_W-1:0]             tick_n;
  logic                          prio_hit;
  logic [2:0]                    prio_word;

  assign wr       = bus_sel & bus_wr;
  assign pend_set = (wr && bus_addr == A_PND_SET) ? bus_wdata : '0;
  assign pend_clr = (wr && bus_addr == A_PND_CLR) ? bus_wdata : '0;

  always_comb begin
    en_n = line_en;
    if (wr && bus_addr == A_EN_SET) en_n = line_en | bus_wdata;
    if (wr && bus_addr == A_EN_CLR) en_n = line_en & ~bus_wdata;
    prio_n = line_prio;
    for (int i = 0; i < NLINES; i++) begin
      if (wr && bus_addr == ADDR_W'(int'(A_PRIO) + BYTES_PER_WORD * (i / BYTES_PER_WORD)))
        prio_n[i] = bus_wdata[8 * (i % BYTES_PER_WORD) + LOW_ZERO +: PRIO_W];
    end
    tick_n = tick_prio;
    if (wr && bus_addr == A_TICKPRIO) tick_n = bus_wdata[DATA_W-PRIO_W +: PRIO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_en   <= '0;
      line_prio <= '0;
      tick_prio <= '0;
    end else begin
      line_en   <= en_n;
      line_prio <= prio_n;
      tick_prio <= tick_n;
    end
  end

  assign prio_hit  = (bus_addr[ADDR_W-1:5] == A_PRIO[ADDR_W-1:5]) && (bus_addr[1:0] == 2'b00);
  assign prio_word = bus_addr[4:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_EN_SET || bus_addr == A_EN_CLR)        bus_rdata = line_en;
    else if (bus_addr == A_PND_SET || bus_addr == A_PND_CLR) bus_rdata = line_pend;
    else if (bus_addr == A_TICKPRIO)  bus_rdata[DATA_W-PRIO_W +: PRIO_W] = tick_prio;
    else if (prio_hit) begin
      for (int j = 0; j < BYTES_PER_WORD; j++)
        bus_rdata[8*j +: 8] = {line_prio[int'(prio_word) * BYTES_PER_WORD + j], {LOW_ZERO{1'b0}}};
    end
  end
endmodule

// File: rtl/vpic_state.sv
module vpic_state
  import vpic_pkg::*;
#(
  parameter logic [NLINES-1:0] PULSE_LINES = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NSYS-1:0]   sys_req,
  input  logic [NLINES-1:0] pend_set,
  input  logic [NLINES-1:0] pend_clr,
  input  logic [NLINES-1:0] take_line,
  input  logic [NSYS-1:0]   take_sys,
  input  logic [NLINES-1:0] ret_line,
  input  logic [NSYS-1:0]   ret_sys,
  output logic [NLINES-1:0] pend_line,
  output logic [NSYS-1:0]   pend_sys,
  output logic [NLINES-1:0] act_line,
  output logic [NSYS-1:0]   act_sys
);
  logic [NLINES-1:0] irq_q;
  logic [NLINES-1:0] capture;
  logic [NLINES-1:0] pend_line_n, act_line_n;
  logic [NSYS-1:0]   pend_sys_n, act_sys_n;

  for (genvar g = 0; g < NLINES; g++) begin : g_cap
    if (PULSE_LINES[g]) begin : g_edge
      assign capture[g] = irq_in[g] & ~irq_q[g];
    end else begin : g_level
      assign capture[g] = irq_in[g] & ~act_line[g] & ~take_line[g];
    end
  end

  always_comb begin
    pend_line_n = (pend_line & ~pend_clr & ~take_line) | pend_set | capture;
    act_line_n  = (act_line | take_line) & ~ret_line;
    pend_sys_n  = (pend_sys & ~take_sys) | sys_req;
    act_sys_n   = (act_sys | take_sys) & ~ret_sys;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= '0;
      pend_line <= '0;
      act_line  <= '0;
      pend_sys  <= '0;
      act_sys   <= '0;
    end else begin
      irq_q     <= irq_in;
      pend_line <= pend_line_n;
      act_line  <= act_line_n;
      pend_sys  <= pend_sys_n;
      act_sys   <= act_sys_n;
    end
  end
endmodule

// File: rtl/vpic_select.sv
module vpic_select
  import vpic_pkg::*;
(
  input  logic [NEXC-1:0]             req,
  input  logic [NEXC-1:0][RANK_W-1:0] rank,
  output logic                        hit,
  output logic [NUM_W-1:0]            num,
  output logic [RANK_W-1:0]           best
);
  // scan from the top so that lower numbers overwrite on equal rank
  always_comb begin
    hit  = 1'b0;
    num  = '0;
    best = RANK_NONE;
    for (int i = NEXC - 1; i >= 0; i--) begin
      if (req[i] && rank[i] <= best) begin
        hit  = 1'b1;
        num  = NUM_W'(i);
        best = rank[i];
      end
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE    = 32'h0000_0000,
  parameter logic [NLINES-1:0] PULSE_LINES = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic [NSYS-1:0]   sys_req,
  input  logic              ent_take,
  input  logic              ret_take,
  input  logic [NUM_W-1:0]  ret_num,
  output logic              irq_valid,
  output logic [NUM_W-1:0]  irq_num,
  output logic [DATA_W-1:0] irq_vector,
  output logic              irq_preempt
);
  localparam int SYS_EXC [NSYS] = '{EXC_NMI, EXC_HF, EXC_TICK};

  logic [NLINES-1:0]             line_en, line_pend, line_act, pend_set, pend_clr;
  logic [NLINES-1:0][PRIO_W-1:0] line_prio;
  logic [PRIO_W-1:0]             tick_prio;
  logic [NSYS-1:0]               sys_pend, sys_act, take_sys, ret_sys;
  logic [NLINES-1:0]             take_line, ret_line;
  logic [NEXC-1:0]               pend_vec, act_vec;
  logic [NEXC-1:0][RANK_W-1:0]   ex_rank;
  logic [RANK_W-1:0]             win_rank, act_rank;
  logic                          act_any;
  logic [NUM_W-1:0]              act_num;
  logic                          take_ok;

  assign take_ok = ent_take & irq_valid;

  vpic_regfile u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .line_pend (line_pend), .bus_rdata, .line_en, .line_prio, .tick_prio,
    .pend_set, .pend_clr
  );

  vpic_state #(.PULSE_LINES(PULSE_LINES)) u_state (
    .clk, .rst_n, .irq_in, .sys_req, .pend_set, .pend_clr,
    .take_line, .take_sys, .ret_line, .ret_sys,
    .pend_line (line_pend), .pend_sys (sys_pend),
    .act_line  (line_act),  .act_sys  (sys_act)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    localparam int E = LINE_BASE + n;
    assign take_line[n]    = take_ok  && irq_num == NUM_W'(E);
    assign ret_line[n]     = ret_take && ret_num == NUM_W'(E);
    assign pend_vec[E]     = line_pend[n] & line_en[n];
    assign act_vec[E]      = line_act[n];
    assign ex_rank[E]      = RANK_W'(2) + RANK_W'(line_prio[n]);
  end

  for (genvar s = 0; s < NSYS; s++) begin : g_sysmap
    assign take_sys[s] = take_ok  && irq_num == NUM_W'(SYS_EXC[s]);
    assign ret_sys[s]  = ret_take && ret_num == NUM_W'(SYS_EXC[s]);
  end

  for (genvar e = 0; e < LINE_BASE; e++) begin : g_sysexc
    if (e == EXC_NMI) begin : g_nmi
      assign pend_vec[e] = sys_pend[0];
      assign act_vec[e]  = sys_act[0];
      assign ex_rank[e]  = RANK_W'(0);
    end else if (e == EXC_HF) begin : g_hf
      assign pend_vec[e] = sys_pend[1];
      assign act_vec[e]  = sys_act[1];
      assign ex_rank[e]  = RANK_W'(1);
    end else if (e == EXC_TICK) begin : g_tick
      assign pend_vec[e] = sys_pend[2];
      assign act_vec[e]  = sys_act[2];
      assign ex_rank[e]  = RANK_W'(2) + RANK_W'(tick_prio);
    end else begin : g_none
      assign pend_vec[e] = 1'b0;
      assign act_vec[e]  = 1'b0;
      assign ex_rank[e]  = RANK_NONE;
    end
  end

  vpic_select u_sel_pend (
    .req (pend_vec), .rank (ex_rank), .hit (irq_valid), .num (irq_num), .best (win_rank)
  );

  vpic_select u_sel_act (
    .req (act_vec), .rank (ex_rank), .hit (act_any), .num (act_num), .best (act_rank)
  );

  assign irq_vector  = VEC_BASE + {{(DATA_W-NUM_W-2){1'b0}}, irq_num, 2'b00};
  assign irq_preempt = irq_valid && (!act_any || win_rank < act_rank);

  logic unused_ok;
  assign unused_ok = ^act_num;
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NLINES-1:0] line_en,
  input logic [NLINES-1:0] line_pend,
  input logic              nmi_pend,
  input logic [NEXC-1:0]   act_vec,
  input logic              ent_take,
  input logic              ret_take,
  input logic [NUM_W-1:0]  ret_num,
  input logic              irq_valid,
  input logic [NUM_W-1:0]  irq_num,
  input logic              irq_preempt
);
  AST_SETEN_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_EN_SET) |=> ((line_en & $past(line_en)) == $past(line_en))); // R2
  AST_CLREN_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_EN_CLR) |=> ((line_en & ~$past(line_en)) == '0)); // R2
  AST_ENABLED_PEND_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|(line_en & line_pend)) |-> irq_valid); // R5
  AST_NMI_ALWAYS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_valid && irq_num == NUM_W'(EXC_NMI))); // R6
  AST_PREEMPT_NEEDS_CHOICE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_preempt |-> irq_valid); // R8
  AST_ENTRY_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_take && irq_valid && !(ret_take && ret_num == irq_num)) |=> act_vec[$past(irq_num)]); // R9
endmodule

bind vpic_top vpic_checker i_vpic_checker (
  .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr,
  .line_en   (line_en),
  .line_pend (line_pend),
  .nmi_pend  (sys_pend[0]),
  .act_vec   (act_vec),
  .ent_take, .ret_take, .ret_num, .irq_valid, .irq_num, .irq_preempt
);

// File: tb/test_vpic_top.sv
module test_vpic_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] irq_in;
  logic [2:0]  sys_req;
  logic        ent_take, ret_take;
  logic [5:0]  ret_num;
  logic        irq_valid, irq_preempt;
  logic [5:0]  irq_num;
  logic [31:0] irq_vector;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  vpic_top i_vpic_top (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_in, .sys_req, .ent_take, .ret_take, .ret_num,
    .irq_valid, .irq_num, .irq_vector, .irq_preempt
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic take();
    @(negedge clk); ent_take = 1;
    @(negedge clk); ent_take = 0;
  endtask

  task automatic give_back(input logic [5:0] n);
    @(negedge clk); ret_take = 1; ret_num = n;
    @(negedge clk); ret_take = 0;
  endtask

  task automatic sys_pulse(input int k);
    @(negedge clk); sys_req[k] = 1;
    @(negedge clk); sys_req[k] = 0;
  endtask

  task automatic chosen(input string tag, input logic v, input logic [5:0] n, input logic p);
    #1;
    check({tag, " valid"}, {31'b0, irq_valid}, {31'b0, v});
    if (v) begin
      check({tag, " num"}, {26'b0, irq_num}, {26'b0, n});
      check({tag, " preempt"}, {31'b0, irq_preempt}, {31'b0, p});
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h100, d); check("R12 enable", d, 0);
    rd(12'h200, d); check("R12 pending", d, 0);
    rd(12'h41C, d); check("R12 priority", d, 0);
    chosen("R12 idle", 0, 0, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(12'h100, 32'h0000_00A5); rd(12'h100, d); check("R2 set", d, 32'hA5);
    rd(12'h180, d); check("R2 read clr addr", d, 32'hA5);
    wr(12'h100, 32'h0);  rd(12'h100, d); check("R2 set zero", d, 32'hA5);
    wr(12'h180, 32'h05); rd(12'h100, d); check("R2 clear", d, 32'hA0);
    wr(12'h180, 32'h0);  rd(12'h100, d); check("R2 clear zero", d, 32'hA0);
    wr(12'h180, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h404, 32'hFFFF_FFFF); rd(12'h404, d); check("R4 masked", d, 32'hC0C0_C0C0);
    wr(12'h404, 32'h4080_C000); rd(12'h404, d); check("R4 bytes", d, 32'h4080_C000);
    rd(12'h400, d); check("R4 neighbour", d, 0);
    wr(12'h404, 32'h0);
  endtask

  task automatic t_pend_sw();
    logic [31:0] d;
    wr(12'h200, 32'h0010_0000); rd(12'h280, d); check("R3 set", d, 32'h0010_0000);
    chosen("R5 not enabled", 0, 0, 0);
    wr(12'h100, 32'h0010_0000); chosen("R1 line20", 1, 36, 1);
    check("R1 vector", irq_vector, 32'h90);
    wr(12'h280, 32'h0); rd(12'h200, d); check("R3 clear zero", d, 32'h0010_0000);
    wr(12'h280, 32'h0010_0000); rd(12'h200, d); check("R3 clear", d, 0);
    wr(12'h200, 32'h8000_0000); wr(12'h100, 32'h8000_0000);
    chosen("R1 line31", 1, 47, 1); check("R1 vector47", irq_vector, 32'hBC);
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF);
  endtask

  task automatic t_tie();
    wr(12'h100, 32'h28); wr(12'h200, 32'h28);
    chosen("R5 tie", 1, 19, 1);
    wr(12'h400, 32'h4000_0000); chosen("R5 line3 worse", 1, 21, 1);
    wr(12'h404, 32'h0000_8000); chosen("R5 line5 worse", 1, 19, 1);
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h400, 0); wr(12'h404, 0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    wr(12'h100, 32'h80);
    @(negedge clk) irq_in[7] = 1;
    @(negedge clk); chosen("R10 edge", 1, 23, 1);
    take(); rd(12'h200, d); check("R10 taken", d, 0);
    give_back(23); @(negedge clk); rd(12'h200, d); check("R10 held high", d, 0);
    @(negedge clk) irq_in[7] = 0;
    @(negedge clk) irq_in[7] = 1;
    @(negedge clk); rd(12'h200, d); check("R10 new edge", d, 32'h80);
    irq_in[7] = 0;
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(12'h100, 32'h0004_0000);
    @(negedge clk) irq_in[18] = 1;
    @(negedge clk); chosen("R11 level", 1, 34, 1);
    take(); rd(12'h200, d); check("R9 take clears", d, 0);
    chosen("R9 active blocks", 0, 0, 0);
    give_back(34); @(negedge clk); rd(12'h200, d); check("R11 repend", d, 32'h0004_0000);
    take(); irq_in[18] = 0;
    give_back(34); @(negedge clk); @(negedge clk);
    rd(12'h200, d); check("R11 low stays", d, 0);
    wr(12'h180, 32'hFFFF_FFFF);
  endtask

  task automatic t_preempt();
    wr(12'h408, 32'h0000_4040); wr(12'h100, 32'h700);
    wr(12'h200, 32'h100); chosen("R8 idle", 1, 24, 1);
    take();
    wr(12'h200, 32'h200); chosen("R8 equal", 1, 25, 0);
    wr(12'h200, 32'h400); chosen("R8 better", 1, 26, 1);
    take(); chosen("R8 nested", 1, 25, 0);
    give_back(26); chosen("R8 after inner", 1, 25, 0);
    give_back(24); chosen("R8 after outer", 1, 25, 1);
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF); wr(12'h408, 0);
  endtask

  task automatic t_sys();
    logic [31:0] d;
    wr(12'hD20, 32'h7FFF_FFFF); rd(12'hD20, d); check("R7 field", d, 32'h4000_0000);
    wr(12'h100, 32'h1); wr(12'h200, 32'h1);
    sys_pulse(2); chosen("R7 line wins", 1, 16, 1);
    wr(12'hD20, 0); chosen("R7 tie tick", 1, 15, 1);
    check("R1 vector tick", irq_vector, 32'h3C);
    sys_pulse(1); chosen("R6 hard fault", 1, 3, 1);
    sys_pulse(0); chosen("R6 nmi", 1, 2, 1);
    take(); chosen("R6 nmi active", 1, 3, 0);
    give_back(2); chosen("R6 after nmi", 1, 3, 1);
    take(); give_back(3); chosen("R6 tick next", 1, 15, 1);
    take(); give_back(15); chosen("R6 line last", 1, 16, 1);
    wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF);
    chosen("R12 drained", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    irq_in = 0; sys_req = 0; ent_take = 0; ret_take = 0; ret_num = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_prio();
    t_pend_sw();
    t_tie();
    t_pulse();
    t_level();
    t_preempt();
    t_sys();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule